// File: doc/BRIEF.md
# Processor Status Flag Unit

This block keeps the eight-bit status word of a small accumulator processor and works out each flag's next value every cycle. The execution unit sends it qualified update strobes: an arithmetic result with its carry and signed-overflow outputs, a shift or rotate result, a plain data-transfer result, or a bit-test operand with the accumulator value. Decode logic sends a set vector and a clear vector, with one bit per flag. The stack path reads a byte to push and hands back a popped byte to restore.

The live word drives branch decisions and interrupt masking. The break position always reads 0 in the live word. It appears as 1 only in the byte pushed for a software break. When an add or subtract runs in decimal mode, the block marks the zero, overflow and negative flags as not meaningful. They stay marked that way until a later binary-meaningful update rewrites them. The block also combines a pending hardware interrupt with the interrupt-disable flag and a software-break request to decide whether an interrupt is taken.

Top module: `psw_flag_unit`

## Requirements
- R1: Reset (rst_n low) sets the live word `psw_o` to 8'h04, with only interrupt-disable at 1, and sets `znv_valid_o` to 1. The word keeps that value while no update is requested.
- R2: The live word places carry at bit 0, zero at bit 1, interrupt-disable at bit 2, decimal at bit 3, break at bit 4, memory-to-memory mode at bit 5, overflow at bit 6 and negative at bit 7. Bit k of `set_cmd_i` sets flag k and bit k of `clr_cmd_i` clears it, from the next cycle. Set works only on bits 0, 2, 3 and 5. Clear works only on bits 0, 2, 3, 5 and 6. Commands on other bits change nothing.
- R3: When set and clear are both requested for the same flag in one cycle, the clear wins.
- R4: An arithmetic update loads carry from `alu_carry_i` and overflow from `alu_ovf_i`. Zero becomes 1 exactly when `alu_res_i` is 0, and negative becomes the top bit of `alu_res_i`.
- R5: A shift update writes carry, zero and negative as in R4 and leaves overflow unchanged.
- R6: A load update writes only zero and negative from `alu_res_i`. Carry and overflow keep their values.
- R7: A bit-test update copies operand bit 6 into overflow and operand bit 7 into negative. Zero becomes 1 exactly when `alu_res_i & bit_opnd_i` is 0. Carry is unchanged.
- R8: A set or clear command on a flag overrides every other update of that flag in the same cycle, including a pull.
- R9: When several update strobes arrive in one cycle, only one source acts. Priority runs pull, then arithmetic, then shift, then bit-test, then load.
- R10: A pull loads every bit of `pull_byte_i` except bit 4, and the live break bit stays 0.
- R11: In the same cycle, `push_byte_o` equals the live word with bit 4 replaced by `brk_push_i`.
- R12: An arithmetic update that wins arbitration with `dec_addsub_i` high, while the live decimal flag is 1, drives `znv_valid_o` to 0 in the next cycle. Any other winning update drives it to 1. A cycle with no winning update, or with commands only, leaves it unchanged.
- R13: `irq_accept_o` is 1 when `sw_brk_i` is 1, or when `irq_req_i` is 1 and interrupt-disable is 0. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_cmd_i | input | 8 | Per-flag set command |
| clr_cmd_i | input | 8 | Per-flag clear command |
| arith_upd_i | input | 1 | Arithmetic result update strobe |
| shift_upd_i | input | 1 | Shift/rotate result update strobe |
| load_upd_i | input | 1 | Data-transfer result update strobe |
| bit_upd_i | input | 1 | Bit-test update strobe |
| pull_upd_i | input | 1 | Restore word from popped byte |
| dec_addsub_i | input | 1 | Current arithmetic op is add/subtract (decimal capable) |
| alu_res_i | input | DATA_W | Result byte, or accumulator during bit-test |
| alu_carry_i | input | 1 | Carry/borrow out of the ALU |
| alu_ovf_i | input | 1 | Signed overflow out of the ALU |
| bit_opnd_i | input | DATA_W | Memory operand of bit-test |
| pull_byte_i | input | 8 | Byte popped from the stack |
| brk_push_i | input | 1 | Push is for a software break |
| irq_req_i | input | 1 | Hardware interrupt pending |
| sw_brk_i | input | 1 | Software break requested |
| psw_o | output | 8 | Live status word |
| push_byte_o | output | 8 | Byte to write onto the stack |
| znv_valid_o | output | 1 | Zero/overflow/negative are meaningful |
| irq_accept_o | output | 1 | Interrupt taken |

## Verification
Commands are swept over all eight bit positions, which separates the set-capable flags from the clear-only overflow flag. A mapping error would show up as a stray flag or a missing one. The arithmetic, shift, load and bit-test paths each run through every result byte. The checks look for a flag that should be left alone but moves, such as a load that disturbs carry or a shift that clobbers overflow, and for zero or negative taken from the wrong byte. Multi-strobe cycles are chosen so that each pair of sources produces a different word, so a wrong priority shows at once. The checks also cover: every pulled byte with a break bit that must not stick; the push byte under both break settings; the decimal-validity marker across set, hold and recovery; and the interrupt gate over all input combinations.

// File: rtl/psw_pkg.sv
package psw_pkg;

   localparam int PSW_W = 8;

   // flag positions inside the status word
   localparam int BIT_C = 0;
   localparam int BIT_Z = 1;
   localparam int BIT_I = 2;
   localparam int BIT_D = 3;
   localparam int BIT_B = 4;
   localparam int BIT_T = 5;
   localparam int BIT_V = 6;
   localparam int BIT_N = 7;

   // which flags have explicit commands
   localparam logic [PSW_W-1:0] SET_CAPABLE = 8'b0010_1101;
   localparam logic [PSW_W-1:0] CLR_CAPABLE = 8'b0110_1101;

   // winning hardware update source, highest priority first in the arbiter
   typedef enum logic [2:0] {
      SRC_NONE  = 3'd0,
      SRC_PULL  = 3'd1,
      SRC_ARITH = 3'd2,
      SRC_SHIFT = 3'd3,
      SRC_BIT   = 3'd4,
      SRC_LOAD  = 3'd5
   } psw_src_e;

   function automatic logic [PSW_W-1:0] flag_bit(input int idx);
      logic [PSW_W-1:0] m;
      m = '0;
      m[idx] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/psw_src_arbiter.sv
module psw_src_arbiter
   import psw_pkg::*;
(
   input  logic     pull_i,
   input  logic     arith_i,
   input  logic     shift_i,
   input  logic     bittest_i,
   input  logic     load_i,
   output psw_src_e src_o
);

   localparam int NUM_SRC = 5;

   logic     [NUM_SRC-1:0] req;
   psw_src_e               code [NUM_SRC];

   assign req = {load_i, bittest_i, shift_i, arith_i, pull_i};

   assign code[0] = SRC_PULL;
   assign code[1] = SRC_ARITH;
   assign code[2] = SRC_SHIFT;
   assign code[3] = SRC_BIT;
   assign code[4] = SRC_LOAD;

   // lowest index wins: scan from the bottom priority upward
   always_comb begin
      src_o = SRC_NONE;
      for (int k = NUM_SRC - 1; k >= 0; k--) begin
         if (req[k]) src_o = code[k];
      end
   end

endmodule

// File: rtl/psw_alu_flags.sv
module psw_alu_flags
   import psw_pkg::*;
#(
   parameter int DATA_W = 8
)
(
   input  psw_src_e          src_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              carry_i,
   input  logic              ovf_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [PSW_W-1:0]  pull_byte_i,
   output logic [PSW_W-1:0]  we_o,
   output logic [PSW_W-1:0]  val_o
);

   localparam int MSB  = DATA_W - 1;
   localparam int NMSB = DATA_W - 2;

   initial begin
      CHK_DATA_W: assert (DATA_W >= 2 && DATA_W <= 64)
         else $error("psw_alu_flags: DATA_W out of range");
   end

   logic res_zero;
   logic res_neg;
   logic and_zero;

   assign res_zero = ~|res_i;
   assign res_neg  = res_i[MSB];
   assign and_zero = ~|(res_i & opnd_i);

   always_comb begin
      we_o  = '0;
      val_o = '0;
      unique case (src_i)
         SRC_PULL: begin
            we_o  = ~flag_bit(BIT_B);
            val_o = pull_byte_i;
         end
         SRC_ARITH: begin
            we_o         = flag_bit(BIT_C) | flag_bit(BIT_Z) | flag_bit(BIT_V) | flag_bit(BIT_N);
            val_o[BIT_C] = carry_i;
            val_o[BIT_Z] = res_zero;
            val_o[BIT_V] = ovf_i;
            val_o[BIT_N] = res_neg;
         end
         SRC_SHIFT: begin
            we_o         = flag_bit(BIT_C) | flag_bit(BIT_Z) | flag_bit(BIT_N);
            val_o[BIT_C] = carry_i;
            val_o[BIT_Z] = res_zero;
            val_o[BIT_N] = res_neg;
         end
         SRC_BIT: begin
            we_o         = flag_bit(BIT_Z) | flag_bit(BIT_V) | flag_bit(BIT_N);
            val_o[BIT_Z] = and_zero;
            val_o[BIT_V] = opnd_i[NMSB];
            val_o[BIT_N] = opnd_i[MSB];
         end
         SRC_LOAD: begin
            we_o         = flag_bit(BIT_Z) | flag_bit(BIT_N);
            val_o[BIT_Z] = res_zero;
            val_o[BIT_N] = res_neg;
         end
         default: begin
            we_o  = '0;
            val_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/psw_cmd_mask.sv
module psw_cmd_mask
   import psw_pkg::*;
#(
   parameter bit T_EN   = 1'b1,
   parameter bit DEC_EN = 1'b1
)
(
   input  logic [PSW_W-1:0] set_i,
   input  logic [PSW_W-1:0] clr_i,
   output logic [PSW_W-1:0] we_o,
   output logic [PSW_W-1:0] val_o
);

   localparam logic [PSW_W-1:0] OPT_OFF =
      (T_EN   ? '0 : flag_bit(BIT_T)) |
      (DEC_EN ? '0 : flag_bit(BIT_D));
   localparam logic [PSW_W-1:0] SET_OK = SET_CAPABLE & ~OPT_OFF;
   localparam logic [PSW_W-1:0] CLR_OK = CLR_CAPABLE & ~OPT_OFF;

   initial begin
      CHK_SET_SUBSET: assert ((SET_OK & ~CLR_OK) == '0)
         else $error("psw_cmd_mask: settable flag without clear");
   end

   for (genvar k = 0; k < PSW_W; k++) begin : g_flag
      logic set_eff;
      logic clr_eff;
      assign set_eff  = set_i[k] & SET_OK[k];
      assign clr_eff  = clr_i[k] & CLR_OK[k];
      assign we_o[k]  = set_eff | clr_eff;
      assign val_o[k] = ~clr_eff;
   end

endmodule

// File: rtl/psw_dec_valid.sv
module psw_dec_valid
   import psw_pkg::*;
#(
   parameter bit DEC_EN = 1'b1
)
(
   input  logic     clk,
   input  logic     rst_n,
   input  psw_src_e src_i,
   input  logic     addsub_i,
   input  logic     dmode_i,
   output logic     valid_o
);

   if (DEC_EN) begin : g_track
      logic valid_q;
      logic dec_hit;

      assign dec_hit = (src_i == SRC_ARITH) && addsub_i && dmode_i;

      always_ff @(posedge clk) begin
         if (!rst_n)                  valid_q <= 1'b1;
         else if (dec_hit)            valid_q <= 1'b0;
         else if (src_i != SRC_NONE)  valid_q <= 1'b1;
      end

      assign valid_o = valid_q;

      AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (src_i == SRC_NONE) |=> (valid_o == $past(valid_o))); // R12

      AST_VALID_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
         (src_i != SRC_NONE && src_i != SRC_ARITH) |=> valid_o); // R12
   end else begin : g_always
      assign valid_o = 1'b1;
   end

endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
   import psw_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit T_EN      = 1'b1,
   parameter bit DEC_EN    = 1'b1,
   parameter bit RST_IMASK = 1'b1
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        set_cmd_i,
   input  logic [7:0]        clr_cmd_i,
   input  logic              arith_upd_i,
   input  logic              shift_upd_i,
   input  logic              load_upd_i,
   input  logic              bit_upd_i,
   input  logic              pull_upd_i,
   input  logic              dec_addsub_i,
   input  logic [DATA_W-1:0] alu_res_i,
   input  logic              alu_carry_i,
   input  logic              alu_ovf_i,
   input  logic [DATA_W-1:0] bit_opnd_i,
   input  logic [7:0]        pull_byte_i,
   input  logic              brk_push_i,
   input  logic              irq_req_i,
   input  logic              sw_brk_i,
   output logic [7:0]        psw_o,
   output logic [7:0]        push_byte_o,
   output logic              znv_valid_o,
   output logic              irq_accept_o
);

   // bits that can ever hold a 1 in the live word
   localparam logic [PSW_W-1:0] LIVE_MASK =
      ~flag_bit(BIT_B) &
      ~(T_EN   ? '0 : flag_bit(BIT_T)) &
      ~(DEC_EN ? '0 : flag_bit(BIT_D));
   localparam logic [PSW_W-1:0] RST_VAL = RST_IMASK ? flag_bit(BIT_I) : '0;

   initial begin
      CHK_PSW_W: assert (PSW_W == 8)
         else $error("psw_flag_unit: status word must be one byte");
   end

   psw_src_e           src;
   logic [PSW_W-1:0]   hw_we;
   logic [PSW_W-1:0]   hw_val;
   logic [PSW_W-1:0]   cmd_we;
   logic [PSW_W-1:0]   cmd_val;
   logic [PSW_W-1:0]   cand;
   logic [PSW_W-1:0]   psw_q;

   psw_src_arbiter u_arb (
      .pull_i    (pull_upd_i),
      .arith_i   (arith_upd_i),
      .shift_i   (shift_upd_i),
      .bittest_i (bit_upd_i),
      .load_i    (load_upd_i),
      .src_o     (src)
   );

   psw_alu_flags #(.DATA_W(DATA_W)) u_alu (
      .src_i       (src),
      .res_i       (alu_res_i),
      .carry_i     (alu_carry_i),
      .ovf_i       (alu_ovf_i),
      .opnd_i      (bit_opnd_i),
      .pull_byte_i (pull_byte_i),
      .we_o        (hw_we),
      .val_o       (hw_val)
   );

   psw_cmd_mask #(.T_EN(T_EN), .DEC_EN(DEC_EN)) u_cmd (
      .set_i (set_cmd_i),
      .clr_i (clr_cmd_i),
      .we_o  (cmd_we),
      .val_o (cmd_val)
   );

   // per-flag merge: command first, then the winning hardware source
   for (genvar k = 0; k < PSW_W; k++) begin : g_merge
      assign cand[k] = cmd_we[k] ? cmd_val[k] :
                       hw_we[k]  ? hw_val[k]  : psw_q[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) psw_q <= RST_VAL;
      else        psw_q <= cand & LIVE_MASK;
   end

   psw_dec_valid #(.DEC_EN(DEC_EN)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src),
      .addsub_i (dec_addsub_i),
      .dmode_i  (psw_q[BIT_D]),
      .valid_o  (znv_valid_o)
   );

   for (genvar k = 0; k < PSW_W; k++) begin : g_push
      if (k == BIT_B) begin : g_brk
         assign push_byte_o[k] = brk_push_i;
      end else begin : g_live
         assign push_byte_o[k] = psw_q[k];
      end
   end

   assign psw_o        = psw_q;
   assign irq_accept_o = sw_brk_i | (irq_req_i & ~psw_q[BIT_I]);

   AST_SET_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (set_cmd_i[BIT_C] && !clr_cmd_i[BIT_C]) |=> psw_o[BIT_C]); // R2

   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd_i[BIT_I] |=> !psw_o[BIT_I]); // R3

   AST_CMD_OVER_ALU: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd_i[BIT_V] && (arith_upd_i || bit_upd_i || pull_upd_i)) |=> !psw_o[BIT_V]); // R8

   AST_ZERO_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
      (arith_upd_i && !pull_upd_i && alu_res_i == '0) |=> psw_o[BIT_Z]); // R4

   AST_LOAD_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (load_upd_i && !arith_upd_i && !shift_upd_i && !pull_upd_i &&
       !set_cmd_i[BIT_C] && !clr_cmd_i[BIT_C])
      |=> (psw_o[BIT_C] == $past(psw_o[BIT_C]))); // R6

   AST_PULL_NO_BRK: assert property (@(posedge clk) disable iff (!rst_n)
      pull_upd_i |=> !psw_o[BIT_B]); // R10

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (psw_o[BIT_I] && !sw_brk_i) |-> !irq_accept_o); // R13

   if (DEC_EN) begin : g_dec_ast
      AST_DEC_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
         (arith_upd_i && !pull_upd_i && dec_addsub_i && psw_o[BIT_D]) |=> !znv_valid_o); // R12
   end

endmodule

// File: tb/psw_flag_unit_test.sv
module psw_flag_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] set_cmd, clr_cmd;
   logic       arith_upd, shift_upd, load_upd, bit_upd, pull_upd, dec_addsub;
   logic [7:0] alu_res, bit_opnd, pull_byte;
   logic       alu_carry, alu_ovf, brk_push, irq_req, sw_brk;
   logic [7:0] psw, push_byte;
   logic       znv_valid, irq_accept;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;
   logic [7:0] e;

   always #10 clk = ~clk;

   psw_flag_unit uut (
      .clk(clk), .rst_n(rst_n), .set_cmd_i(set_cmd), .clr_cmd_i(clr_cmd),
      .arith_upd_i(arith_upd), .shift_upd_i(shift_upd), .load_upd_i(load_upd),
      .bit_upd_i(bit_upd), .pull_upd_i(pull_upd), .dec_addsub_i(dec_addsub),
      .alu_res_i(alu_res), .alu_carry_i(alu_carry), .alu_ovf_i(alu_ovf),
      .bit_opnd_i(bit_opnd), .pull_byte_i(pull_byte), .brk_push_i(brk_push),
      .irq_req_i(irq_req), .sw_brk_i(sw_brk), .psw_o(psw), .push_byte_o(push_byte),
      .znv_valid_o(znv_valid), .irq_accept_o(irq_accept)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic idle();
      set_cmd = '0; clr_cmd = '0;
      arith_upd = 0; shift_upd = 0; load_upd = 0; bit_upd = 0; pull_upd = 0;
      dec_addsub = 0; alu_res = '0; bit_opnd = '0; pull_byte = '0;
      alu_carry = 0; alu_ovf = 0; brk_push = 0; irq_req = 0; sw_brk = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic do_pull(input logic [7:0] b);
      pull_upd = 1; pull_byte = b;
      tick(); idle();
   endtask

   initial begin
      idle();
      repeat (3) tick();
      chk("R1 reset word", psw, 8'h04);
      chk("R1 reset valid", {7'd0, znv_valid}, 8'h01);
      rst_n = 1;
      repeat (2) tick();
      chk("R1 idle hold", psw, 8'h04);

      // R2 set sweep
      do_pull(8'h00); e = 8'h00;
      for (int k = 0; k < 8; k++) begin
         set_cmd = 8'h01 << k; tick(); idle();
         e = e | ((8'h01 << k) & 8'h2D);
         chk("R2 set", psw, e);
      end
      // R2 clear sweep
      do_pull(8'hFF); e = 8'hEF;
      for (int k = 0; k < 8; k++) begin
         clr_cmd = 8'h01 << k; tick(); idle();
         e = e & ~((8'h01 << k) & 8'h6D);
         chk("R2 clear", psw, e);
      end
      // R3 set and clear together
      for (int k = 0; k < 8; k++) begin
         do_pull(8'hFF);
         set_cmd = 8'h01 << k; clr_cmd = 8'h01 << k; tick(); idle();
         chk("R3 clear wins", psw, 8'hEF & ~((8'h01 << k) & 8'h6D));
      end

      // R4 arithmetic sweep
      do_pull(8'h00); e = 8'h00;
      for (int a = 0; a < 256; a++) begin
         logic [7:0] v;
         v = a[7:0];
         arith_upd = 1; alu_res = v; alu_carry = v[2]; alu_ovf = v[5];
         tick(); idle();
         e = (e & 8'h3C) | {v[7], v[5], 4'b0000, (v == 8'h00), v[2]};
         chk("R4 arith", psw, e);
      end
      chk("R12 binary arith valid", {7'd0, znv_valid}, 8'h01);

      // R5 shift sweep, overflow held at 1
      do_pull(8'h40); e = 8'h40;
      for (int a = 0; a < 256; a++) begin
         logic [7:0] v;
         v = a[7:0];
         shift_upd = 1; alu_res = v; alu_carry = ~v[0];
         tick(); idle();
         e = (e & 8'h7C) | {v[7], 5'b00000, (v == 8'h00), ~v[0]};
         chk("R5 shift", psw, e);
      end

      // R6 load sweep, carry and overflow held at 1
      do_pull(8'h41); e = 8'h41;
      for (int a = 0; a < 256; a++) begin
         logic [7:0] v;
         v = a[7:0];
         load_upd = 1; alu_res = v; alu_carry = 0; alu_ovf = 0;
         tick(); idle();
         e = (e & 8'h7D) | {v[7], 5'b00000, (v == 8'h00), 1'b0};
         chk("R6 load", psw, e);
      end

      // R7 bit-test sweep, carry held at 1
      do_pull(8'h01); e = 8'h01;
      for (int o = 0; o < 256; o++) begin
         logic [7:0] op, acc;
         op  = o[7:0];
         acc = {op[3:0], op[7:4]} ^ 8'h0F;
         bit_upd = 1; bit_opnd = op; alu_res = acc; alu_carry = 0;
         tick(); idle();
         e = (e & 8'h3D) | {op[7], op[6], 4'b0000, ((acc & op) == 8'h00), 1'b0};
         chk("R7 bit test", psw, e);
      end

      // R8 commands beat hardware sources
      do_pull(8'h00);
      set_cmd = 8'h01; arith_upd = 1; alu_res = 8'h01; alu_carry = 0; tick(); idle();
      chk("R8 set C over arith", psw, 8'h01);
      clr_cmd = 8'h40; arith_upd = 1; alu_res = 8'h80; alu_carry = 1; alu_ovf = 1; tick(); idle();
      chk("R8 clr V over arith", psw, 8'h81);
      clr_cmd = 8'h01; shift_upd = 1; alu_res = 8'h00; alu_carry = 1; tick(); idle();
      chk("R8 clr C over shift", psw, 8'h02);
      set_cmd = 8'h04; pull_upd = 1; pull_byte = 8'h00; tick(); idle();
      chk("R8 set I over pull", psw, 8'h04);

      // R9 source priority
      do_pull(8'h00);
      pull_upd = 1; pull_byte = 8'h01; arith_upd = 1; alu_res = 8'h80; alu_ovf = 1; tick(); idle();
      chk("R9 pull over arith", psw, 8'h01);
      arith_upd = 1; load_upd = 1; alu_res = 8'h00; alu_carry = 0; alu_ovf = 1; tick(); idle();
      chk("R9 arith over load", psw, 8'h42);
      shift_upd = 1; bit_upd = 1; alu_res = 8'h01; bit_opnd = 8'hC0; alu_carry = 0; tick(); idle();
      chk("R9 shift over bit", psw, 8'h40);
      bit_upd = 1; load_upd = 1; alu_res = 8'h00; bit_opnd = 8'h80; tick(); idle();
      chk("R9 bit over load", psw, 8'h82);

      // R10 pull sweep with R11 push byte
      for (int b = 0; b < 256; b++) begin
         do_pull(b[7:0]);
         chk("R10 pull", psw, b[7:0] & 8'hEF);
         brk_push = 0; #1;
         chk("R11 push plain", push_byte, b[7:0] & 8'hEF);
         brk_push = 1; #1;
         chk("R11 push break", push_byte, (b[7:0] & 8'hEF) | 8'h10);
         idle();
      end

      // R12 decimal validity
      do_pull(8'h08);
      chk("R12 valid after pull", {7'd0, znv_valid}, 8'h01);
      arith_upd = 1; dec_addsub = 1; tick(); idle();
      chk("R12 decimal add invalid", {7'd0, znv_valid}, 8'h00);
      set_cmd = 8'h01; tick(); idle();
      chk("R12 command holds", {7'd0, znv_valid}, 8'h00);
      tick();
      chk("R12 idle holds", {7'd0, znv_valid}, 8'h00);
      shift_upd = 1; tick(); idle();
      chk("R12 shift restores", {7'd0, znv_valid}, 8'h01);
      arith_upd = 1; dec_addsub = 1; tick(); idle();
      chk("R12 decimal again", {7'd0, znv_valid}, 8'h00);
      arith_upd = 1; dec_addsub = 0; tick(); idle();
      chk("R12 non-addsub arith", {7'd0, znv_valid}, 8'h01);
      do_pull(8'h00);
      arith_upd = 1; dec_addsub = 1; tick(); idle();
      chk("R12 binary addsub", {7'd0, znv_valid}, 8'h01);

      // R13 interrupt gate
      for (int i = 0; i < 2; i++) begin
         do_pull(i[0] ? 8'h04 : 8'h00);
         for (int c = 0; c < 4; c++) begin
            irq_req = c[0]; sw_brk = c[1]; #1;
            chk("R13 irq gate", {7'd0, irq_accept}, {7'd0, c[1] | (c[0] & ~i[0])});
         end
         idle();
      end

      // R1 reset from a disturbed state
      do_pull(8'hEB);
      arith_upd = 1; dec_addsub = 1; alu_res = 8'h80; tick(); idle();
      rst_n = 0; tick();
      chk("R1 re-reset word", psw, 8'h04);
      chk("R1 re-reset valid", {7'd0, znv_valid}, 8'h01);
      rst_n = 1; tick();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule